// File: doc/BRIEF.md
# Channel-Status and User-Bit Block Buffer

This block sits behind an AES3 / S/PDIF subframe decoder. For every decoded subframe it accepts the channel-status (C) bit and the user (U) bit, tagged as channel A or channel B. It assembles them into a fill-side buffer that holds one full block of frames for both channels. When the last subframe of a block arrives, the whole block moves into a host-side buffer in a single clock. The fill side then starts the next block at once. Each completed move gives a one-cycle event pulse, which can be used as an interrupt.

The host reads the host-side buffer through a small byte port. The port has a pointer load with an address, a read strobe and a write strobe. The pointer steps by itself after each access, so a whole block can be read as one burst. Channel-status data can be read one byte at a time from a chosen channel, or as an A/B byte pair per word. User data is always read as a pair of bytes, with the bits of the two channels interleaved.

The host can block moves while it reads, so that a long burst sees stable data. It can also keep the first words of the channel-status buffer as host-written values that moves do not overwrite.

Top module: `cu_block_store`

## Requirements
- R1: After reset, `host_rdata` and `block_done` are 0, and every host-side byte (C and U, both channels) reads as 0.
- R2: The C or U bit of frame f goes to word f/8, at bit position 7-(f mod 8), so the earliest bit is the MSB. A channel-A strobe with `sf_block_start` high is frame 0. A block cut short by an early block start is dropped and produces no move.
- R3: The move happens on the clock edge after the edge that accepts the channel-B strobe of frame FRAMES-1. On that edge `block_done` is high for exactly one cycle.
- R4: If `copy_inhibit` is high when a move falls due, the move is dropped. No pulse is given and the host-side data stays unchanged. The next full block is moved normally.
- R5: With `reserve_en` high, a move leaves C words 0 to RSV_WORDS-1 of both channels unchanged. Every other C word and all U words are still moved.
- R6: `host_wr` stores `host_wdata` into the C host-side byte at the pointer. It uses the same channel choice and the same pointer stepping as a C read.
- R7: In one-byte mode (`one_byte`=1, `read_user`=0), a read returns the C byte of channel B if `pick_b`=1, or of channel A if `pick_b`=0. The pointer steps by one word after each read.
- R8: In two-byte mode (`one_byte`=0), reads return the A byte of the word first and then the B byte. The pointer steps after the B byte.
- R9: With `read_user`=1, each word is read as two bytes, whatever the mode. The first byte is A7 B7 A6 B6 A5 B5 A4 B4 and the second is A3 B3 A2 B2 A1 B1 A0 B0, MSB first.
- R10: `host_load` with `host_addr` from BASE (20h) to BASE+NW-1 (37h) selects word `host_addr`-BASE and starts at the first byte. Any other address gives reads of 0, leaves the pointer where it is and ignores writes.
- R11: After the last word, the pointer wraps to word 0.
- R12: `host_rdata` is registered. It changes only on the edge that accepts `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Subframe bit strobe |
| sf_chan_b | input | 1 | Strobe belongs to channel B (0 = A) |
| sf_c | input | 1 | Channel-status bit of the subframe |
| sf_u | input | 1 | User bit of the subframe |
| sf_block_start | input | 1 | Channel-A strobe is frame 0 of a block |
| copy_inhibit | input | 1 | Drop moves that fall due |
| reserve_en | input | 1 | Protect the first C words from moves |
| one_byte | input | 1 | One-byte C access (0 = two-byte) |
| pick_b | input | 1 | Channel choice in one-byte mode |
| read_user | input | 1 | Read U data instead of C data |
| host_load | input | 1 | Load the pointer from host_addr |
| host_addr | input | 7 | Host address |
| host_rd | input | 1 | Read one byte and step |
| host_wr | input | 1 | Write one C byte and step |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| block_done | output | 1 | One-cycle pulse per completed move |

## Verification
On every cycle, the assertions check the following. Move pulses are single cycles and never follow an inhibited cycle. Read data holds still between reads. Reads outside the window return zero. The pointer stays inside the window. A reserved word stays unchanged across moves. Other behaviour can only be shown by the bench's block scenarios: bit placement, the A/B byte order and the U interleave, pointer wrap, dropped and truncated blocks, and host writes surviving a move. For these, the bench sends patterned blocks and computes each expected byte from the frame number.

// File: rtl/cu_block_store.sv
module cu_block_store #(
  parameter int FRAMES = 192,
  parameter int RSV_WORDS = 5,
  parameter int AW = 7,
  parameter logic [AW-1:0] BASE = 7'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sf_valid,
  input  logic          sf_chan_b,
  input  logic          sf_c,
  input  logic          sf_u,
  input  logic          sf_block_start,
  input  logic          copy_inhibit,
  input  logic          reserve_en,
  input  logic          one_byte,
  input  logic          pick_b,
  input  logic          read_user,
  input  logic          host_load,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          block_done
);
  localparam int NW = FRAMES / 8;
  localparam int FW = $clog2(FRAMES);
  localparam int PW = FW - 3;
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);
  localparam logic [PW-1:0] LASTW = PW'(NW - 1);
  localparam logic [AW-1:0] NWA = AW'(NW);

  logic [7:0] d_ca [NW];
  logic [7:0] d_cb [NW];
  logic [7:0] d_ua [NW];
  logic [7:0] d_ub [NW];
  logic [7:0] e_ca [NW];
  logic [7:0] e_cb [NW];
  logic [7:0] e_ua [NW];
  logic [7:0] e_ub [NW];

  logic [FW-1:0] next_idx, a_idx;
  logic          copy_pend;
  logic [PW-1:0] ptr;
  logic          phase, ptr_ok;

  wire [FW-1:0]  cur      = sf_block_start ? '0 : next_idx;
  wire           do_copy  = copy_pend && !copy_inhibit;
  wire           two      = read_user || !one_byte;
  wire           sel_b    = two ? phase : pick_b;
  wire [AW-1:0]  off      = host_addr - BASE;
  wire           in_win   = off < NWA;
  wire           acc_rd   = host_rd && !host_load;
  wire           acc_wr   = host_wr && !host_rd && !host_load && ptr_ok;
  wire [PW-1:0]  ptr_nxt  = (ptr == LASTW) ? '0 : ptr + 1'b1;

  function automatic logic [7:0] ilv(input logic [7:0] a, input logic [7:0] b, input logic hi);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[7-2*i] = hi ? a[7-i] : a[3-i];
      r[6-2*i] = hi ? b[7-i] : b[3-i];
    end
    return r;
  endfunction

  logic [7:0] rbyte;
  always_comb begin
    if (read_user) rbyte = ilv(e_ua[ptr], e_ub[ptr], !phase);
    else           rbyte = sel_b ? e_cb[ptr] : e_ca[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_idx  <= '0;
      a_idx     <= '0;
      copy_pend <= 1'b0;
      for (int k = 0; k < NW; k++) begin
        d_ca[k] <= '0; d_cb[k] <= '0; d_ua[k] <= '0; d_ub[k] <= '0;
      end
    end else begin
      copy_pend <= sf_valid && sf_chan_b && (a_idx == LAST);
      if (sf_valid && !sf_chan_b) begin
        d_ca[cur[FW-1:3]][~cur[2:0]] <= sf_c;
        d_ua[cur[FW-1:3]][~cur[2:0]] <= sf_u;
        a_idx <= cur;
      end else if (sf_valid) begin
        d_cb[a_idx[FW-1:3]][~a_idx[2:0]] <= sf_c;
        d_ub[a_idx[FW-1:3]][~a_idx[2:0]] <= sf_u;
        next_idx <= (a_idx == LAST) ? '0 : a_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      block_done <= 1'b0;
      for (int k = 0; k < NW; k++) begin
        e_ca[k] <= '0; e_cb[k] <= '0; e_ua[k] <= '0; e_ub[k] <= '0;
      end
    end else begin
      block_done <= do_copy;
      if (do_copy) begin
        for (int k = 0; k < NW; k++) begin
          if (!(reserve_en && k < RSV_WORDS)) begin
            e_ca[k] <= d_ca[k];
            e_cb[k] <= d_cb[k];
          end
          e_ua[k] <= d_ua[k];
          e_ub[k] <= d_ub[k];
        end
      end
      if (acc_wr) begin
        if (sel_b) e_cb[ptr] <= host_wdata;
        else       e_ca[ptr] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      phase      <= 1'b0;
      ptr_ok     <= 1'b1;
      host_rdata <= '0;
    end else if (host_load) begin
      ptr_ok <= in_win;
      phase  <= 1'b0;
      if (in_win) ptr <= off[PW-1:0];
    end else if (acc_rd || acc_wr) begin
      if (acc_rd) host_rdata <= ptr_ok ? rbyte : 8'h00;
      if (ptr_ok) begin
        if (two) begin
          phase <= !phase;
          if (phase) ptr <= ptr_nxt;
        end else begin
          ptr <= ptr_nxt;
        end
      end
    end
  end
endmodule

module cu_block_store_chk #(
  parameter int NW = 24,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          copy_inhibit,
  input logic          block_done,
  input logic          host_rd,
  input logic          host_load,
  input logic          host_wr,
  input logic          reserve_en,
  input logic          ptr_ok,
  input logic [PW-1:0] ptr,
  input logic [7:0]    host_rdata,
  input logic [7:0]    e_res
);
  assert_pulse_after_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> !$past(copy_inhibit));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);
  assert_rdata_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
  assert_outside_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_load && !ptr_ok) |=> (host_rdata == 8'h00));
  assert_ptr_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NW);
  assert_reserved_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reserve_en && !host_wr) |=> $stable(e_res));
endmodule

bind cu_block_store cu_block_store_chk #(.NW(NW), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .copy_inhibit(copy_inhibit), .block_done(block_done),
  .host_rd(host_rd), .host_load(host_load), .host_wr(host_wr),
  .reserve_en(reserve_en), .ptr_ok(ptr_ok), .ptr(ptr),
  .host_rdata(host_rdata), .e_res(e_ca[0])
);

// File: tb/cu_block_store_test.sv
`timescale 1ns/1ps
module cu_block_store_test;
  localparam int FR = 192;
  localparam int NW = FR / 8;

  logic clk = 0, rst_n = 0;
  logic sf_valid = 0, sf_chan_b = 0, sf_c = 0, sf_u = 0, sf_block_start = 0;
  logic copy_inhibit = 0, reserve_en = 0, one_byte = 0, pick_b = 0, read_user = 0;
  logic host_load = 0, host_rd = 0, host_wr = 0;
  logic [6:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic block_done;

  int checks = 0, fails = 0, evt_cnt = 0;

  always #2.5 clk = ~clk;

  cu_block_store uut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b), .sf_c(sf_c),
    .sf_u(sf_u), .sf_block_start(sf_block_start), .copy_inhibit(copy_inhibit),
    .reserve_en(reserve_en), .one_byte(one_byte), .pick_b(pick_b), .read_user(read_user),
    .host_load(host_load), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .block_done(block_done)
  );

  always @(negedge clk) if (rst_n && block_done) evt_cnt++;

  function automatic logic cpat(int f, int ch, int s);
    return ((f * 7 + ch * 3 + s * 5) % 11) < 5;
  endfunction
  function automatic logic upat(int f, int ch, int s);
    return ((f * 13 + ch * 5 + s) % 7) < 3;
  endfunction
  function automatic logic [7:0] exp_c(int ch, int j, int s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = cpat(8*j+i, ch, s);
    return b;
  endfunction
  function automatic logic [7:0] exp_u(int j, int hi, int s);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      b[7-2*i] = upat(8*j + (hi ? i : i+4), 0, s);
      b[6-2*i] = upat(8*j + (hi ? i : i+4), 1, s);
    end
    return b;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_block(int s, int nfr);
    for (int f = 0; f < nfr; f++)
      for (int ch = 0; ch < 2; ch++) begin
        @(negedge clk);
        sf_valid = 1; sf_chan_b = ch[0]; sf_block_start = (f == 0 && ch == 0);
        sf_c = cpat(f, ch, s); sf_u = upat(f, ch, s);
      end
    @(negedge clk);
    sf_valid = 0; sf_block_start = 0;
  endtask

  task automatic load(logic [6:0] a);
    @(negedge clk); host_load = 1; host_addr = a;
    @(negedge clk); host_load = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); host_wr = 1; host_wdata = v;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", host_rdata, 0);
    chk("R1 done", block_done, 0);
    load(7'h20);
    for (int j = 0; j < NW; j++) begin
      rd(v); chk("R1 C A", v, 0);
      rd(v); chk("R1 C B", v, 0);
    end
    read_user = 1;
    for (int j = 0; j < 2 * NW; j++) begin rd(v); chk("R1 U", v, 0); end
    read_user = 0;

    send_block(1, FR);
    chk("R3 done not yet", block_done, 0);
    @(negedge clk); chk("R3 done pulse", block_done, 1);
    @(negedge clk); chk("R3 done one cycle", block_done, 0);
    chk("R3 event count", evt_cnt, 1);

    load(7'h20);
    for (int j = 0; j < NW; j++) begin
      rd(v); chk("R8 R2 A byte", v, exp_c(0, j, 1));
      rd(v); chk("R8 R2 B byte", v, exp_c(1, j, 1));
    end
    rd(v); chk("R11 wrap two-byte", v, exp_c(0, 0, 1));
    one_byte = 1; pick_b = 0; load(7'h20);
    for (int j = 0; j < NW; j++) begin rd(v); chk("R7 A", v, exp_c(0, j, 1)); end
    rd(v); chk("R11 wrap one-byte", v, exp_c(0, 0, 1));
    pick_b = 1; load(7'h20);
    for (int j = 0; j < NW; j++) begin rd(v); chk("R7 B", v, exp_c(1, j, 1)); end
    read_user = 1; load(7'h20);
    for (int j = 0; j < NW; j++) begin
      rd(v); chk("R9 U hi", v, exp_u(j, 1, 1));
      rd(v); chk("R9 U lo", v, exp_u(j, 0, 1));
    end
    read_user = 0; pick_b = 0;

    load(7'h25); rd(v); chk("R10 load 25h", v, exp_c(0, 5, 1));
    load(7'h1F); rd(v); chk("R10 below window", v, 0);
    load(7'h38); rd(v); chk("R10 above window", v, 0);
    wr(8'h77);
    load(7'h37); rd(v); chk("R10 last word", v, exp_c(0, NW-1, 1));
    rd(v); chk("R11 wrap from 37h", v, exp_c(0, 0, 1));

    copy_inhibit = 1; e0 = evt_cnt;
    send_block(2, FR); repeat (3) @(negedge clk);
    chk("R4 no pulse", evt_cnt, e0);
    load(7'h23); rd(v); chk("R4 data kept", v, exp_c(0, 3, 1));
    copy_inhibit = 0;
    send_block(3, FR); repeat (3) @(negedge clk);
    chk("R4 next block pulse", evt_cnt, e0 + 1);
    load(7'h23); rd(v); chk("R4 next block data", v, exp_c(0, 3, 3));

    one_byte = 0; load(7'h20);
    for (int k = 0; k < 10; k++) wr(8'hA0 + 8'(k));
    load(7'h20);
    for (int k = 0; k < 10; k++) begin rd(v); chk("R6 write readback", v, 8'hA0 + k); end
    reserve_en = 1;
    send_block(4, FR); repeat (3) @(negedge clk);
    load(7'h20);
    for (int k = 0; k < 10; k++) begin rd(v); chk("R5 reserved kept", v, 8'hA0 + k); end
    rd(v); chk("R5 word5 A moved", v, exp_c(0, 5, 4));
    rd(v); chk("R5 word5 B moved", v, exp_c(1, 5, 4));
    read_user = 1; load(7'h20);
    rd(v); chk("R5 U moved", v, exp_u(0, 1, 4));
    read_user = 0;
    one_byte = 1; pick_b = 1; load(7'h22); wr(8'h5C);
    load(7'h22); rd(v); chk("R6 one-byte write B", v, 8'h5C);
    pick_b = 0; load(7'h22); rd(v); chk("R6 A untouched", v, 8'hA4);
    reserve_en = 0;
    send_block(5, FR); repeat (3) @(negedge clk);
    load(7'h20); rd(v); chk("R5 reserve off moves", v, exp_c(0, 0, 5));

    e0 = evt_cnt;
    send_block(6, 100);
    send_block(7, FR); repeat (3) @(negedge clk);
    chk("R2 short block dropped", evt_cnt, e0 + 1);
    one_byte = 0; load(7'h20);
    for (int j = 0; j < NW; j++) begin
      rd(v); chk("R2 restart A", v, exp_c(0, j, 7));
      rd(v); chk("R2 restart B", v, exp_c(1, j, 7));
    end
    summary();
  end
endmodule